// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is one arithmetic slice for a DSP datapath. Two operands, `d` and the low 25 bits of `a`, meet in a 25-bit pre-adder. Its result is multiplied by the signed 18-bit `b`. The 48-bit product then joins a three-input adder/subtractor. The adder's X, Y and Z operands come from multiplexers steered by a 7-bit operation word. Those sources include the product, the `{a,b}` concatenation, the `c` word, the slice's own result, and a cascade input from a neighbouring slice. The cascade input and the result can each be fed back with an arithmetic right shift of 17 bits, which lets wide products be assembled across several slices.

Parameters choose whether each pipeline stage is present: the input operands, C, the product, the control word and the output. Each stage has its own clock enable and synchronous reset. The output stage holds the result, carry-out, pattern flag and product sign. The same register drives the cascade outputs for the next slice. A pattern comparator flags results that match a parameter value in every bit that `c` leaves unmasked.

Top module: `mac_slice`

## Requirements
- R1: Each stage's reset is synchronous and takes priority over its clock enable. One edge with `rst_p` high clears `p`, `carry_out`, `pat_hit`, `pc_out`, `cc_out` and `msign_out` to zero.
- R2: While `ce_p` is low, the output stage holds `p`, `carry_out`, `pat_hit` and the cascade outputs unchanged, whatever the other inputs do.
- R3: `pre_ctl` sets the multiplicand: 2'b01 gives `d + a[24:0]`, 2'b11 gives `d - a[24:0]`, and 2'b00 or 2'b10 gives `a[24:0]`. The pre-add wraps modulo 2^25. The signed product of this value and `b` is sign-extended to 48 bits.
- R4: The operation word sets the adder operands.
  - `opmode[1:0]` (X): 0 selects zero, 1 the product, 2 `p`, 3 `{a,b}`.
  - `opmode[3:2]` (Y): 0 selects zero, 1 the product, 2 `c`, 3 reserved (zero).
  - `opmode[6:4]` (Z): 0 selects zero, 1 `pc_in`, 2 `p`, 3 `c`, 5 `pc_in` shifted, 6 `p` shifted, 4 and 7 reserved (zero).
  - The product is added once when X=1 and Y=1 together.
- R5: `opmode_bad` is high exactly when one of X and Y selects the product and the other does not, or Y=3, or Z is 4 or 7. A product selected on only one of X and Y contributes zero.
- R6: When `alu_mode` is 2'b11 the result is Z - (X + Y + CIN). For any other value it is Z + X + Y + CIN. Both wrap modulo 2^48.
- R7: `carry_sel` picks CIN: 0 takes `carry_in` and 1 takes `cc_in`. On an add, `carry_out` is 1 when the unsigned sum reaches 2^48. On a subtract, it is 1 when unsigned Z is at least X + Y + CIN.
- R8: The Z shift choices are an arithmetic right shift by 17, so bit 47 fills the vacated upper bits.
- R9: `pat_hit` is 1 when the result equals PATTERN (default zero) in every bit position where `c` is 0. It is registered with `p`.
- R10: `pc_out` equals `p` and `cc_out` equals `carry_out`. `msign_out` is bit 47 of the product that fed the result. All three come from the output register.
- R11: With every stage enabled (default), a change reaches `p` after a set number of clock edges:
  - `a`, `b` and `d` on the product path take 3 edges.
  - `c`, the `{a,b}` operand and the control inputs take 2 edges.
  - `pc_in`, `carry_in` and `cc_in` take 1 edge.
- R12: With Z=2 and the product on X and Y, `p` grows by the product on every edge, so it accumulates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| a | input | 30 | Pre-adder operand (low 25 bits) and upper part of the `{a,b}` operand |
| b | input | 18 | Multiplier operand and lower part of the `{a,b}` operand |
| c | input | 48 | Adder operand and pattern mask |
| d | input | 25 | Pre-adder operand |
| pre_ctl | input | 2 | Pre-adder function |
| opmode | input | 7 | Z/Y/X operand selects |
| alu_mode | input | 2 | Add or subtract |
| carry_sel | input | 1 | Carry-in source |
| carry_in | input | 1 | External carry-in |
| pc_in | input | 48 | Cascade result from the neighbouring slice |
| cc_in | input | 1 | Cascade carry from the neighbouring slice |
| ce_in | input | 1 | Enable for the a/b/d/pre_ctl stage |
| rst_in | input | 1 | Synchronous reset for the a/b/d/pre_ctl stage |
| ce_c | input | 1 | Enable for the C stage |
| rst_c | input | 1 | Synchronous reset for the C stage |
| ce_m | input | 1 | Enable for the product stage |
| rst_m | input | 1 | Synchronous reset for the product stage |
| ce_ctl | input | 1 | Enable for the control stage |
| rst_ctl | input | 1 | Synchronous reset for the control stage |
| ce_p | input | 1 | Enable for the output stage |
| rst_p | input | 1 | Synchronous reset for the output stage |
| p | output | 48 | Result |
| carry_out | output | 1 | Adder carry-out |
| pat_hit | output | 1 | Masked pattern match |
| pc_out | output | 48 | Cascade result to the next slice |
| cc_out | output | 1 | Cascade carry to the next slice |
| msign_out | output | 1 | Product sign to the next slice |
| opmode_bad | output | 1 | Illegal operand-select combination |

## Verification
Feedback through `p` and a change in the control word can meet at the adder in the same cycle. A new operation word arrives through the control stage, while the output register still holds a value computed under the previous word. The bench provokes this by switching into accumulate or shifted-feedback mode from a steady state. It then requires that the first edge still applies the old operation and that each later edge applies the new one to the previous `p`. The same collision is set up for the output enable: the inputs change while `ce_p` is low, and `p` must then take up the new value on the first enabled edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int W_A    = 30;
    localparam int W_B    = 18;
    localparam int W_C    = 48;
    localparam int W_D    = 25;
    localparam int W_P    = 48;
    localparam int W_PRE  = 25;
    localparam int W_M    = W_PRE + W_B;
    localparam int W_SUM  = W_P + 2;
    localparam int SHIFT  = 17;

    typedef enum logic [1:0] {
        XS_ZERO = 2'd0, XS_MUL = 2'd1, XS_P = 2'd2, XS_AB = 2'd3
    } xsel_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'd0, YS_MUL = 2'd1, YS_C = 2'd2, YS_RSV = 2'd3
    } ysel_e;

    typedef enum logic [2:0] {
        ZS_ZERO = 3'd0, ZS_PCIN = 3'd1, ZS_P = 3'd2, ZS_C = 3'd3,
        ZS_RSV4 = 3'd4, ZS_PCIN_SH = 3'd5, ZS_P_SH = 3'd6, ZS_RSV7 = 3'd7
    } zsel_e;

    typedef struct packed {
        zsel_e z;
        ysel_e y;
        xsel_e x;
    } opmode_t;

    typedef struct packed {
        opmode_t    op;
        logic [1:0] alu;
        logic       csel;
    } ctl_t;

    typedef struct packed {
        logic [W_A-1:0] a;
        logic [W_B-1:0] b;
        logic [W_D-1:0] d;
        logic [1:0]     pre;
    } in_t;

    typedef struct packed {
        logic [W_P-1:0] p;
        logic           co;
        logic           hit;
        logic           msign;
    } out_t;

    function automatic logic op_illegal(opmode_t o);
        return ((o.x == XS_MUL) != (o.y == YS_MUL)) || (o.y == YS_RSV) ||
               (o.z == ZS_RSV4) || (o.z == ZS_RSV7);
    endfunction

    function automatic logic [W_P-1:0] sra_cascade(logic [W_P-1:0] v);
        logic signed [W_P-1:0] s;
        s = v;
        return W_P'(s >>> SHIFT);
    endfunction

endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
    parameter int W  = 1,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN) begin : g_reg
            logic [W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)     r <= '0;
                else if (ce) r <= d;
            end
            assign q = r;
        end else begin : g_bypass
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst, ce};
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/mac_preadd_mult.sv
module mac_preadd_mult
    import mac_pkg::*;
(
    input  logic [W_PRE-1:0] a_lo,
    input  logic [W_D-1:0]   d,
    input  logic [W_B-1:0]   b,
    input  logic [1:0]       pre_ctl,
    output logic [W_P-1:0]   prod
);
    logic [W_PRE-1:0]       pre;
    logic signed [W_M-1:0]  m;

    always_comb begin
        case (pre_ctl)
            2'b01:   pre = d + a_lo;
            2'b11:   pre = d - a_lo;
            default: pre = a_lo;
        endcase
    end

    assign m    = $signed({{W_B{pre[W_PRE-1]}}, pre}) * $signed({{W_PRE{b[W_B-1]}}, b});
    assign prod = {{(W_P - W_M){m[W_M-1]}}, m};
endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_pkg::*;
#(
    parameter logic [W_P-1:0] PATTERN = '0
) (
    input  ctl_t           ctl,
    input  logic [W_P-1:0] prod,
    input  logic [W_P-1:0] ab,
    input  logic [W_C-1:0] c,
    input  logic [W_P-1:0] pc_in,
    input  logic [W_P-1:0] p_fb,
    input  logic           cin_ext,
    input  logic           cc_in,
    output logic [W_P-1:0] result,
    output logic           co,
    output logic           hit,
    output logic           bad
);
    logic [W_P-1:0]   xv, yv, zv;
    logic             both_mul, cin;
    logic [W_SUM-1:0] sxy, zx, tot;

    always_comb begin
        both_mul = (ctl.op.x == XS_MUL) && (ctl.op.y == YS_MUL);
        case (ctl.op.x)
            XS_MUL:  xv = both_mul ? prod : '0;
            XS_P:    xv = p_fb;
            XS_AB:   xv = ab;
            default: xv = '0;
        endcase
        yv = (ctl.op.y == YS_C) ? c : '0;
        case (ctl.op.z)
            ZS_PCIN:    zv = pc_in;
            ZS_P:       zv = p_fb;
            ZS_C:       zv = c;
            ZS_PCIN_SH: zv = sra_cascade(pc_in);
            ZS_P_SH:    zv = sra_cascade(p_fb);
            default:    zv = '0;
        endcase
        cin = ctl.csel ? cc_in : cin_ext;
        sxy = {2'b00, xv} + {2'b00, yv} + W_SUM'(cin);
        zx  = {2'b00, zv};
        tot = zx + sxy;
        if (ctl.alu == 2'b11) begin
            result = zv - sxy[W_P-1:0];
            co     = (zx >= sxy);
        end else begin
            result = tot[W_P-1:0];
            co     = |tot[W_SUM-1:W_P];
        end
        hit = (((result ^ PATTERN) & ~c) == '0);
        bad = op_illegal(ctl.op);
    end
endmodule

// File: rtl/mac_slice.sv
module mac_slice
    import mac_pkg::*;
#(
    parameter bit IN_REG  = 1'b1,
    parameter bit C_REG   = 1'b1,
    parameter bit M_REG   = 1'b1,
    parameter bit CTL_REG = 1'b1,
    parameter bit P_REG   = 1'b1,
    parameter logic [W_P-1:0] PATTERN = '0
) (
    input  logic             clk,
    input  logic [W_A-1:0]   a,
    input  logic [W_B-1:0]   b,
    input  logic [W_C-1:0]   c,
    input  logic [W_D-1:0]   d,
    input  logic [1:0]       pre_ctl,
    input  logic [6:0]       opmode,
    input  logic [1:0]       alu_mode,
    input  logic             carry_sel,
    input  logic             carry_in,
    input  logic [W_P-1:0]   pc_in,
    input  logic             cc_in,
    input  logic             ce_in,
    input  logic             rst_in,
    input  logic             ce_c,
    input  logic             rst_c,
    input  logic             ce_m,
    input  logic             rst_m,
    input  logic             ce_ctl,
    input  logic             rst_ctl,
    input  logic             ce_p,
    input  logic             rst_p,
    output logic [W_P-1:0]   p,
    output logic             carry_out,
    output logic             pat_hit,
    output logic [W_P-1:0]   pc_out,
    output logic             cc_out,
    output logic             msign_out,
    output logic             opmode_bad
);
    localparam int W_IN  = $bits(in_t);
    localparam int W_CTL = $bits(ctl_t);
    localparam int W_OUT = $bits(out_t);

    in_t            in_d, in_q;
    ctl_t           ctl_d, ctl_q;
    out_t           out_d, out_q;
    logic [W_C-1:0] c_q;
    logic [W_P-1:0] prod_c, prod_q;

    assign in_d  = {a, b, d, pre_ctl};
    assign ctl_d = {opmode, alu_mode, carry_sel};

    mac_pipe_reg #(.W(W_IN), .EN(IN_REG)) u_in_stage (
        .clk(clk), .rst(rst_in), .ce(ce_in), .d(in_d), .q(in_q));

    mac_pipe_reg #(.W(W_C), .EN(C_REG)) u_c_stage (
        .clk(clk), .rst(rst_c), .ce(ce_c), .d(c), .q(c_q));

    mac_preadd_mult u_mult (
        .a_lo(in_q.a[W_PRE-1:0]), .d(in_q.d), .b(in_q.b),
        .pre_ctl(in_q.pre), .prod(prod_c));

    mac_pipe_reg #(.W(W_P), .EN(M_REG)) u_m_stage (
        .clk(clk), .rst(rst_m), .ce(ce_m), .d(prod_c), .q(prod_q));

    mac_pipe_reg #(.W(W_CTL), .EN(CTL_REG)) u_ctl_stage (
        .clk(clk), .rst(rst_ctl), .ce(ce_ctl), .d(ctl_d), .q(ctl_q));

    mac_alu #(.PATTERN(PATTERN)) u_alu (
        .ctl(ctl_q), .prod(prod_q), .ab({in_q.a, in_q.b}), .c(c_q),
        .pc_in(pc_in), .p_fb(out_q.p), .cin_ext(carry_in), .cc_in(cc_in),
        .result(out_d.p), .co(out_d.co), .hit(out_d.hit), .bad(opmode_bad));

    assign out_d.msign = prod_q[W_P-1];

    mac_pipe_reg #(.W(W_OUT), .EN(P_REG)) u_out_stage (
        .clk(clk), .rst(rst_p), .ce(ce_p), .d(out_d), .q(out_q));

    assign p         = out_q.p;
    assign carry_out = out_q.co;
    assign pat_hit   = out_q.hit;
    assign pc_out    = out_q.p;
    assign cc_out    = out_q.co;
    assign msign_out = out_q.msign;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
    import mac_pkg::*;
#(
    parameter bit CTL_REG = 1'b1,
    parameter bit P_REG   = 1'b1
) (
    input logic           clk,
    input logic [6:0]     opmode,
    input logic [1:0]     alu_mode,
    input logic           carry_sel,
    input logic           carry_in,
    input logic [W_P-1:0] pc_in,
    input logic           ce_ctl,
    input logic           rst_ctl,
    input logic           ce_p,
    input logic           rst_p,
    input logic [W_P-1:0] p,
    input logic           carry_out,
    input logic           pat_hit,
    input logic           opmode_bad
);
    generate
        if (P_REG) begin : g_out
            AST_P_RESET: assert property (@(posedge clk)
                rst_p |=> (p == '0 && !carry_out && !pat_hit)); // R1
            AST_P_HOLD: assert property (@(posedge clk) disable iff (rst_p)
                !ce_p |=> $stable(p)); // R2
        end
        if (CTL_REG) begin : g_ctl
            AST_BAD_FLAG: assert property (@(posedge clk) disable iff (rst_ctl)
                ce_ctl |=> (opmode_bad == op_illegal(opmode_t'($past(opmode))))); // R5
        end
        if (CTL_REG && P_REG) begin : g_casc
            AST_PCIN_PASS: assert property (@(posedge clk) disable iff (rst_p || rst_ctl)
                ($past(ce_ctl) && !$past(rst_ctl) && $past(opmode) == 7'b001_00_00 &&
                 $past(alu_mode) == 2'b00 && !$past(carry_sel) && !carry_in && ce_p)
                |=> (p == $past(pc_in) && !carry_out)); // R4
            AST_PCIN_SHIFT: assert property (@(posedge clk) disable iff (rst_p || rst_ctl)
                ($past(ce_ctl) && !$past(rst_ctl) && $past(opmode) == 7'b101_00_00 &&
                 $past(alu_mode) == 2'b00 && !$past(carry_sel) && !carry_in && ce_p)
                |=> (p == sra_cascade($past(pc_in)))); // R8
        end
    endgenerate
endmodule

bind mac_slice mac_slice_chk #(.CTL_REG(CTL_REG), .P_REG(P_REG)) u_chk (
    .clk(clk), .opmode(opmode), .alu_mode(alu_mode), .carry_sel(carry_sel),
    .carry_in(carry_in), .pc_in(pc_in), .ce_ctl(ce_ctl), .rst_ctl(rst_ctl),
    .ce_p(ce_p), .rst_p(rst_p), .p(p), .carry_out(carry_out),
    .pat_hit(pat_hit), .opmode_bad(opmode_bad));

// File: tb/mac_slice_tb_top.sv
module mac_slice_tb_top;
    localparam time CLK_PERIOD = 10;
    localparam logic [47:0] PAT = 48'h0;

    typedef struct packed {
        logic [47:0] p;
        logic co;
        logic hit;
        logic ms;
        logic bad;
    } exp_t;

    logic clk = 1'b0;
    logic [29:0] a = '0;
    logic [17:0] b = '0;
    logic [47:0] c = '0;
    logic [24:0] d = '0;
    logic [1:0]  pre_ctl = '0;
    logic [6:0]  opmode = '0;
    logic [1:0]  alu_mode = '0;
    logic carry_sel = 1'b0, carry_in = 1'b0, cc_in = 1'b0;
    logic [47:0] pc_in = '0;
    logic ce_in = 1'b1, rst_in = 1'b1, ce_c = 1'b1, rst_c = 1'b1;
    logic ce_m = 1'b1, rst_m = 1'b1, ce_ctl = 1'b1, rst_ctl = 1'b1;
    logic ce_p = 1'b1, rst_p = 1'b1;
    logic [47:0] p, pc_out;
    logic carry_out, pat_hit, cc_out, msign_out, opmode_bad;

    int n_chk = 0;
    int n_err = 0;

    mac_slice dut_i (
        .clk(clk), .a(a), .b(b), .c(c), .d(d), .pre_ctl(pre_ctl),
        .opmode(opmode), .alu_mode(alu_mode), .carry_sel(carry_sel),
        .carry_in(carry_in), .pc_in(pc_in), .cc_in(cc_in),
        .ce_in(ce_in), .rst_in(rst_in), .ce_c(ce_c), .rst_c(rst_c),
        .ce_m(ce_m), .rst_m(rst_m), .ce_ctl(ce_ctl), .rst_ctl(rst_ctl),
        .ce_p(ce_p), .rst_p(rst_p), .p(p), .carry_out(carry_out),
        .pat_hit(pat_hit), .pc_out(pc_out), .cc_out(cc_out),
        .msign_out(msign_out), .opmode_bad(opmode_bad));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk1(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [47:0] sra17(logic [47:0] v);
        logic signed [47:0] s;
        s = v;
        return 48'(s >>> 17);
    endfunction

    function automatic logic [47:0] ref_prod(logic [29:0] av, logic [24:0] dv,
                                             logic [17:0] bv, logic [1:0] pc);
        logic [24:0] m;
        longint prod;
        if (pc == 2'b01)      m = dv + av[24:0];
        else if (pc == 2'b11) m = dv - av[24:0];
        else                  m = av[24:0];
        prod = longint'($signed(m)) * longint'($signed(bv));
        return prod[47:0];
    endfunction

    function automatic exp_t model(logic [47:0] pfb);
        logic [47:0] pr, xv, yv, zv;
        logic [1:0] xs, ys;
        logic [2:0] zs;
        logic ci;
        logic [49:0] s, z50;
        exp_t e;
        pr = ref_prod(a, d, b, pre_ctl);
        xs = opmode[1:0];
        ys = opmode[3:2];
        zs = opmode[6:4];
        xv = '0;
        if (xs == 2'd1 && ys == 2'd1) xv = pr;
        else if (xs == 2'd2)          xv = pfb;
        else if (xs == 2'd3)          xv = {a, b};
        yv = (ys == 2'd2) ? c : '0;
        case (zs)
            3'd1: zv = pc_in;
            3'd2: zv = pfb;
            3'd3: zv = c;
            3'd5: zv = sra17(pc_in);
            3'd6: zv = sra17(pfb);
            default: zv = '0;
        endcase
        ci  = carry_sel ? cc_in : carry_in;
        s   = 50'(xv) + 50'(yv) + 50'(ci);
        z50 = 50'(zv);
        if (alu_mode == 2'b11) begin
            e.p  = 48'(z50 - s);
            e.co = (z50 >= s);
        end else begin
            e.p  = 48'(z50 + s);
            e.co = ((z50 + s) >= 50'h1_0000_0000_0000);
        end
        e.hit = (((e.p ^ PAT) & ~c) == '0);
        e.ms  = pr[47];
        e.bad = ((xs == 2'd1) != (ys == 2'd1)) || ys == 2'd3 || zs == 3'd4 || zs == 3'd7;
        return e;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        exp_t e;
        void'($urandom(32'h5eed_1234));
        cyc(2);
        rst_in = 1'b0; rst_c = 1'b0; rst_m = 1'b0; rst_ctl = 1'b0; rst_p = 1'b0;
        // R1 reset state
        chk("R1", "p after reset", p, 48'h0);
        chk1("R1", "carry after reset", carry_out, 1'b0);
        chk1("R1", "pattern after reset", pat_hit, 1'b0);
        chk1("R1", "msign after reset", msign_out, 1'b0);

        // R3 pre-adder modes
        opmode = 7'b000_01_01; a = 30'd7; d = 25'd5; b = 18'd3;
        pre_ctl = 2'b00; cyc(4); chk("R3", "pre pass a", p, 48'd21);
        pre_ctl = 2'b01; cyc(4); chk("R3", "pre d+a", p, 48'd36);
        pre_ctl = 2'b10; cyc(4); chk("R3", "pre code 10", p, 48'd21);
        pre_ctl = 2'b11; cyc(4); chk("R3", "pre d-a", p, 48'hFFFF_FFFF_FFFA);
        chk1("R10", "msign negative", msign_out, 1'b1);
        chk("R10", "pc_out mirror", pc_out, p);
        chk1("R10", "cc_out mirror", cc_out, carry_out);
        d = 25'h0FF_FFFF; a = 30'd1; b = 18'd1; pre_ctl = 2'b01;
        cyc(4); chk("R3", "pre wrap", p, 48'hFFFF_FF00_0000);

        // R5 illegal selections
        pre_ctl = 2'b00; a = 30'd7; b = 18'd3; c = 48'd100;
        opmode = 7'b011_00_01; cyc(4);
        chk("R5", "lone X product", p, 48'd100);
        chk1("R5", "bad lone X", opmode_bad, 1'b1);
        opmode = 7'b011_11_00; cyc(4); chk1("R5", "bad Y reserved", opmode_bad, 1'b1);
        opmode = 7'b100_01_01; cyc(4);
        chk1("R5", "bad Z reserved", opmode_bad, 1'b1);
        chk("R4", "Z reserved is zero", p, 48'd21);
        opmode = 7'b011_01_01; cyc(4);
        chk1("R5", "legal flag", opmode_bad, 1'b0);
        chk("R4", "C plus product", p, 48'd121);

        // R7 carry and carry source
        opmode = 7'b000_00_11; a = '1; b = '1; carry_in = 1'b1; carry_sel = 1'b0;
        cyc(4); chk("R7", "all ones plus cin", p, 48'h0);
        chk1("R7", "add carry", carry_out, 1'b1);
        carry_sel = 1'b1; cc_in = 1'b0; cyc(4);
        chk("R7", "cascade carry 0", p, 48'hFFFF_FFFF_FFFF);
        chk1("R7", "no carry", carry_out, 1'b0);
        cc_in = 1'b1; cyc(4); chk1("R7", "cascade carry 1", carry_out, 1'b1);
        carry_sel = 1'b0; carry_in = 1'b0; cc_in = 1'b0;

        // R6 subtract
        opmode = 7'b011_00_11; a = '0; b = 18'd3; c = 48'd5; alu_mode = 2'b11;
        cyc(4); chk("R6", "5-3", p, 48'd2); chk1("R7", "sub no borrow", carry_out, 1'b1);
        b = 18'd5; c = 48'd3; cyc(4);
        chk("R6", "3-5", p, 48'hFFFF_FFFF_FFFE); chk1("R7", "sub borrow", carry_out, 1'b0);
        alu_mode = 2'b01; cyc(4); chk("R6", "mode 01 adds", p, 48'd8);
        alu_mode = 2'b00;

        // R8 shift of cascade and of feedback
        opmode = 7'b101_00_00; pc_in = 48'h8000_0000_0000; cyc(4);
        chk("R8", "pc_in shift", p, 48'hFFFF_C000_0000);
        opmode = 7'b001_00_00; cyc(4);
        opmode = 7'b110_00_00; cyc(2);
        chk("R8", "p shift feedback", p, 48'hFFFF_C000_0000);

        // R9 masked pattern
        opmode = 7'b001_00_00; c = 48'hFFFF_FFFF_FF00; pc_in = 48'h1234_5678_9A00;
        cyc(4); chk1("R9", "masked match", pat_hit, 1'b1);
        pc_in = 48'h1234_5678_9A01; cyc(4); chk1("R9", "masked miss", pat_hit, 1'b0);

        // R11 latency per path
        opmode = 7'b000_01_01; a = 30'd2; b = 18'd3; c = '0; cyc(4);
        b = 18'd5;
        cyc(1); chk("R11", "product edge 1", p, 48'd6);
        cyc(1); chk("R11", "product edge 2", p, 48'd6);
        cyc(1); chk("R11", "product edge 3", p, 48'd10);
        opmode = 7'b011_00_00; c = 48'd4; cyc(4); c = 48'd9;
        cyc(1); chk("R11", "c edge 1", p, 48'd4);
        cyc(1); chk("R11", "c edge 2", p, 48'd9);
        opmode = 7'b001_00_00; pc_in = 48'd1; cyc(4); pc_in = 48'd9;
        cyc(1); chk("R11", "pc_in edge 1", p, 48'd9);

        // R12 accumulate, control change meets feedback
        opmode = 7'b000_01_01; a = 30'd7; b = 18'd3; cyc(4);
        opmode = 7'b010_01_01;
        cyc(1); chk("R12", "first edge old op", p, 48'd21);
        cyc(4); chk("R12", "accumulated", p, 48'd105);

        // R2 output hold
        opmode = 7'b001_00_00; pc_in = 48'h55; cyc(4);
        ce_p = 1'b0; pc_in = 48'hAA; cyc(3);
        chk("R2", "held p", p, 48'h55);
        ce_p = 1'b1; cyc(1); chk("R2", "released p", p, 48'hAA);

        // R1 reset priority over enable
        rst_p = 1'b1; cyc(1);
        chk("R1", "rst over ce", p, 48'h0); chk1("R1", "rst cc_out", cc_out, 1'b0);
        rst_p = 1'b0;

        // random operands, feedback-free selections
        for (int i = 0; i < 300; i++) begin
            logic [1:0] xs;
            xs = 2'($urandom_range(0, 2));
            if (xs == 2'd2) xs = 2'd3;
            a = 30'($urandom()); b = 18'($urandom()); d = 25'($urandom());
            c = ($urandom_range(0, 3) == 0) ? 48'hFFFF_FFFF_FF00 : 48'({$urandom(), $urandom()});
            pc_in = 48'({$urandom(), $urandom()});
            pre_ctl = 2'($urandom()); alu_mode = 2'($urandom());
            carry_sel = 1'($urandom()); carry_in = 1'($urandom()); cc_in = 1'($urandom());
            case ($urandom_range(0, 3))
                0: opmode[6:4] = 3'd0;
                1: opmode[6:4] = 3'd1;
                2: opmode[6:4] = 3'd3;
                default: opmode[6:4] = 3'd5;
            endcase
            opmode[3:2] = 2'($urandom());
            opmode[1:0] = xs;
            if ($urandom_range(0, 1) == 0) begin
                opmode[1:0] = 2'd1; opmode[3:2] = 2'd1;
            end
            cyc(4);
            e = model(48'h0);
            chk("R4", "random p", p, e.p);
            chk1("R7", "random carry", carry_out, e.co);
            chk1("R9", "random pattern", pat_hit, e.hit);
            chk1("R10", "random msign", msign_out, e.ms);
            chk1("R5", "random bad flag", opmode_bad, e.bad);
        end

        summary();
        $finish;
    end
endmodule